// File: doc/BRIEF.md
# Converter Start Trigger Selector

This block produces the one-cycle start pulse that launches a conversion sequence in a data-converter controller. A start request can come from a software strobe, which a register write raises for one cycle, or from one hardware event line picked from a small set: several timer compare outputs, one PWM event line and one external trigger pin. A select field names the hardware line and an enable bit gates it. Hardware lines are asynchronous. Each passes through a synchronizer into the converter clock domain, and only a rising edge of the chosen line counts as a request.

The sequencer drives a busy input while a conversion sequence runs. A request that arrives while busy is high does not produce a start pulse. Instead it sets a sticky overrun flag, which stays set until a clear strobe arrives. No data flows through the block, so it has no valid/ready interface. Every pin is a plain control or status wire, and it has no back-pressure.

Top module: `conv_trig_sel`

## Requirements
- R1: A one-cycle high on `sw_start`, sampled at a clock edge, makes `start_pulse` high for the cycle after that edge. This holds for every value of `trig_en` and `trig_sel`.
- R2: `trig_sel` maps hardware sources as follows: codes 0, 1 and 2 select `tmr_evt[0]`, `tmr_evt[1]` and `tmr_evt[2]`; code 3 selects `pwm_evt`; code 4 selects `ext_evt`; codes 5, 6 and 7 select no source and never produce a pulse. A line that is not selected has no effect on `start_pulse`.
- R3: While `trig_en` is 0, no hardware line produces a pulse.
- R4: Only a rising edge of the selected line counts as a request, so a line held high gives exactly one pulse. If the line rises before clock edge k, `start_pulse` is high in the cycle after edge k+2.
- R5: Every hardware-triggered start pulse lasts exactly one clock cycle.
- R6: A change of `trig_sel` or `trig_en` never creates a pulse on its own. This holds even when the newly selected line is already high.
- R7: A request (software strobe or hardware edge) that meets `busy` high in the same cycle produces no start pulse. Instead it sets `overrun` in the following cycle.
- R8: `overrun` stays set until an `ovr_clr` strobe, and it clears in the cycle after that strobe. If a busy-time request and `ovr_clr` arrive in the same cycle, the flag is set.
- R9: After reset, `start_pulse` and `overrun` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start | input | 1 | Software start strobe, one cycle |
| trig_en | input | 1 | Hardware trigger enable |
| trig_sel | input | 3 | Hardware source select code |
| tmr_evt | input | 3 | Timer compare outputs, asynchronous |
| pwm_evt | input | 1 | PWM event line, asynchronous |
| ext_evt | input | 1 | External trigger pin, asynchronous |
| busy | input | 1 | Sequencer is running a sequence |
| ovr_clr | input | 1 | Clear strobe for the overrun flag |
| start_pulse | output | 1 | One-cycle start-of-sequence pulse |
| overrun | output | 1 | Sticky flag: a request arrived while busy |

## Verification
The assertions assume that `sw_start` is a strobe lasting one cycle. They also assume that `busy` and the configuration inputs are synchronous to `clk` and hold steady between edges. Under these conditions, a held software request can never look like back-to-back pulses. The stimulus drives every input on the falling edge, and it asserts `sw_start` and `ovr_clr` for a single cycle only. Event lines move only after the configuration has been stable for several cycles, except in the tests that deliberately change the configuration while a line is high.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int unsigned SEL_W = 3;

  // Positions of the non-timer sources after the timer lines
  localparam int unsigned PWM_OFS = 0;
  localparam int unsigned EXT_OFS = 1;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } trig_cfg_t;
endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stg[STAGES-1];

  // R4: an output bit may rise only if the stage before it was high one cycle earlier
  sync_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sync_o & ~$past(sync_o)) & ~$past(stg[STAGES-2])) == '0);
endmodule

// File: rtl/cts_mux.sv
module cts_mux
  import cts_pkg::*;
#(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic [NUM_SRC-1:0] lines_i,
  input  trig_cfg_t          cfg_i,
  output logic               lvl_o
);
  always_comb begin
    lvl_o = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cfg_i.en && (cfg_i.sel == SEL_W'(i))) lvl_o = lines_i[i];
    end
  end
endmodule

// File: rtl/cts_edge.sv
module cts_edge
  import cts_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl_i,
  input  trig_cfg_t cfg_i,
  output logic      edge_o
);
  logic      prev_q;
  trig_cfg_t cfg_q;
  logic      cfg_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      cfg_q  <= cfg_i;
    end
  end

  assign cfg_chg = (cfg_i != cfg_q);
  assign edge_o  = lvl_i & ~prev_q & ~cfg_chg;

  // R5
  edge_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);

  // R6
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i != $past(cfg_i)) |-> !edge_o);
endmodule

// File: rtl/conv_trig_sel.sv
module conv_trig_sel
  import cts_pkg::*;
#(
  parameter int unsigned NUM_TMR     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_start,
  input  logic               trig_en,
  input  logic [SEL_W-1:0]   trig_sel,
  input  logic [NUM_TMR-1:0] tmr_evt,
  input  logic               pwm_evt,
  input  logic               ext_evt,
  input  logic               busy,
  input  logic               ovr_clr,
  output logic               start_pulse,
  output logic               overrun
);
  localparam int unsigned NUM_SRC = NUM_TMR + 2;

  logic [NUM_SRC-1:0] raw_lines;
  logic [NUM_SRC-1:0] sync_lines;
  trig_cfg_t          cfg;
  logic               sel_lvl;
  logic               hw_edge;
  logic               req;

  assign raw_lines[NUM_TMR-1:0]     = tmr_evt;
  assign raw_lines[NUM_TMR+PWM_OFS] = pwm_evt;
  assign raw_lines[NUM_TMR+EXT_OFS] = ext_evt;
  assign cfg.en  = trig_en;
  assign cfg.sel = trig_sel;

  cts_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_lines),
    .sync_o  (sync_lines)
  );

  cts_mux #(.NUM_SRC(NUM_SRC)) u_mux (
    .lines_i (sync_lines),
    .cfg_i   (cfg),
    .lvl_o   (sel_lvl)
  );

  cts_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (sel_lvl),
    .cfg_i  (cfg),
    .edge_o (hw_edge)
  );

  assign req = hw_edge | sw_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      overrun     <= 1'b0;
    end else begin
      start_pulse <= req & ~busy;
      if (req && busy)  overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
    end
  end

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !$past(busy));

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);

  // R8
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !(req && busy)) |=> !overrun);

  // R3
  hw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_en && !sw_start) |=> !start_pulse);
endmodule

// File: tb/conv_trig_sel_tb.sv
module conv_trig_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_start = 1'b0;
  logic       trig_en = 1'b0;
  logic [2:0] trig_sel = 3'd0;
  logic [4:0] src = 5'd0;
  logic       busy = 1'b0;
  logic       ovr_clr = 1'b0;
  logic       start_pulse;
  logic       overrun;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  conv_trig_sel u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_start    (sw_start),
    .trig_en     (trig_en),
    .trig_sel    (trig_sel),
    .tmr_evt     (src[2:0]),
    .pwm_evt     (src[3]),
    .ext_evt     (src[4]),
    .busy        (busy),
    .ovr_clr     (ovr_clr),
    .start_pulse (start_pulse),
    .overrun     (overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Watch start_pulse for n falling edges; report count and first index (1-based)
  task automatic watch(input int n, output int cnt, output int first);
    cnt = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (start_pulse) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
  endtask

  initial begin
    int cnt, first;
    bit hit;
    idle(3);
    // R9: reset state
    chk(start_pulse == 1'b0, "R9 start_pulse", int'(start_pulse), 0);
    chk(overrun == 1'b0, "R9 overrun", int'(overrun), 0);
    rst_n = 1'b1;
    idle(2);

    // R2 R3 R4 R5: sweep enable x select x source line
    for (int en = 0; en < 2; en++) begin
      for (int sel = 0; sel < 8; sel++) begin
        for (int ln = 0; ln < 5; ln++) begin
          trig_en = en[0]; trig_sel = sel[2:0];
          idle(4);
          src[ln] = 1'b1;
          watch(7, cnt, first);
          hit = (en == 1) && (sel == ln);
          chk(cnt == (hit ? 1 : 0), "R2/R3 pulse count", cnt, hit ? 1 : 0);
          if (hit) chk(first == 3, "R4 latency", first, 3);
          src[ln] = 1'b0;
          idle(4);
        end
      end
    end

    // R1: software start regardless of configuration
    for (int cfgi = 0; cfgi < 16; cfgi++) begin
      trig_en = cfgi[3]; trig_sel = cfgi[2:0];
      idle(3);
      sw_start = 1'b1;
      @(negedge clk);
      chk(start_pulse == 1'b1, "R1 sw pulse", int'(start_pulse), 1);
      sw_start = 1'b0;
      @(negedge clk);
      chk(start_pulse == 1'b0, "R1 sw pulse width", int'(start_pulse), 0);
    end

    // R6: enabling while the selected line is high
    trig_en = 1'b0; trig_sel = 3'd4; src = 5'b10000;
    idle(5);
    trig_en = 1'b1;
    watch(6, cnt, first);
    chk(cnt == 0, "R6 enable with line high", cnt, 0);
    // R6: switching select onto a line that is high
    src = 5'b00001; trig_sel = 3'd1;
    idle(5);
    trig_sel = 3'd0;
    watch(6, cnt, first);
    chk(cnt == 0, "R6 select onto high line", cnt, 0);
    // R4: level held produces nothing further; a fresh edge works
    src = 5'b00000; idle(4);
    src = 5'b00001;
    watch(6, cnt, first);
    chk(cnt == 1 && first == 3, "R4 fresh edge after select", cnt * 10 + first, 13);
    src = 5'b00000; idle(4);

    // R7: software request while busy
    busy = 1'b1; sw_start = 1'b1;
    @(negedge clk);
    chk(start_pulse == 1'b0, "R7 no pulse while busy", int'(start_pulse), 0);
    chk(overrun == 1'b1, "R7 overrun set", int'(overrun), 1);
    sw_start = 1'b0;
    // R8: sticky
    idle(3);
    chk(overrun == 1'b1, "R8 overrun sticky", int'(overrun), 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk(overrun == 1'b0, "R8 overrun cleared", int'(overrun), 0);
    // R8: set wins over clear
    sw_start = 1'b1; ovr_clr = 1'b1;
    @(negedge clk);
    sw_start = 1'b0; ovr_clr = 1'b0;
    chk(overrun == 1'b1, "R8 set beats clear", int'(overrun), 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk(overrun == 1'b0, "R8 clear again", int'(overrun), 0);

    // R7: hardware edge while busy
    trig_en = 1'b1; trig_sel = 3'd3;
    idle(4);
    src[3] = 1'b1;
    watch(6, cnt, first);
    chk(cnt == 0, "R7 hw edge blocked", cnt, 0);
    chk(overrun == 1'b1, "R7 hw overrun", int'(overrun), 1);
    busy = 1'b0; src[3] = 1'b0;
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    idle(3);
    // R5: after busy drops, a new edge gives one pulse of one cycle
    src[3] = 1'b1;
    watch(6, cnt, first);
    chk(cnt == 1 && first == 3, "R5 single-cycle pulse", cnt * 10 + first, 13);
    chk(overrun == 1'b0, "R7 no overrun when idle", int'(overrun), 0);
    src[3] = 1'b0;
    idle(2);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule